// File: doc/BRIEF.md
# Clear-on-Read Interrupt Aggregator

This block merges several independent interrupt sources into one interrupt line for a host. There are three sources: key-scan events (FIFO level or end of a debounce cycle), host-bus timeouts, and general-purpose input changes. Each source raises a one-cycle event pulse. The aggregator captures that pulse in a sticky pending flag. The flag stays set until the host reads that source's status register, which the surrounding logic signals with a one-cycle read strobe.

The interrupt output is a register that follows the OR of all pending flags, one clock later. When more than one source is pending, the host must read each of their status registers before the line drops. Each source has an enable bit. A disabled source records nothing, and turning an enable off discards any flag already pending for that source. The timeout source also has its own one-bit read-only status output.

Source index assignment: bit 0 is the key-scan source, bit 1 is the bus-timeout source, and bit 2 is the general-purpose input source. The enable for bit 1 comes from global configuration bit 5, and the enable for bit 2 comes from global configuration bit 4.

Top module: `irq_aggregator`

## Requirements
- R1: While `rstN` is low, and at the first sampling point after it rises, `statusFlags` reads 0 and `irqOut` reads 0.
- R2: If `srcEnable[i]` and `srcEvent[i]` are both 1 before a rising clock edge, `statusFlags[i]` is 1 after that edge. The flag then holds at 1 while the source stays enabled and is not read.
- R3: If `srcRead[i]` is 1 and `srcEvent[i]` is 0 before an edge, `statusFlags[i]` is 0 after that edge. The other flags are unaffected.
- R4: If `srcEvent[i]` and `srcRead[i]` are both 1 in the same cycle on an enabled source, the event wins and `statusFlags[i]` is 1 after the edge.
- R5: If `srcEnable[i]` is 0 before an edge, a pulse on `srcEvent[i]` does not set the flag, and `statusFlags[i]` is 0 after that edge.
- R6: Clearing `srcEnable[i]` while flag i is pending clears `statusFlags[i]` at the next edge.
- R7: After each edge, `irqOut` equals the OR of `statusFlags` as it stood just before that edge. With several sources pending, `irqOut` stays at 1 until every one of them has been read.
- R8: `timeoutFlag` always equals `statusFlags[1]`, the bus-timeout pending bit.
- R9: A read strobe on a source with no pending flag changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| srcEvent | input | 3 | One-cycle event pulse per source |
| srcEnable | input | 3 | Enable per source (bit 1 = config bit 5, bit 2 = config bit 4) |
| srcRead | input | 3 | One-cycle status-register read strobe per source |
| statusFlags | output | 3 | Sticky pending flag per source |
| timeoutFlag | output | 1 | Read-only bus-timeout pending bit |
| irqOut | output | 1 | Registered combined interrupt |

## Verification
The checker checks every cycle, for each source, the set, hold, clear, event-over-read, disabled-source, and registered-OR relations between inputs and flags. It also checks that the timeout status bit tracks its flag. The bench adds what only sequences can show. Examples are a multi-source interrupt that drops only after the last status read, reads of idle sources that leave the rest untouched, and the reset state. It also sweeps every enable, event and read combination against an arithmetic model from many flag states.

// File: rtl/irq_aggregator_pkg.sv
package irq_aggregator_pkg;
  parameter int unsigned NUM_SRC = 3;
  localparam int unsigned SRC_KEY = 0;
  localparam int unsigned SRC_TMO = 1;
  localparam int unsigned SRC_GPI = 2;

  typedef struct packed {
    logic [NUM_SRC-1:0] setMask;
    logic [NUM_SRC-1:0] clrMask;
  } flagCtl_t;
endpackage

// File: rtl/irq_aggregator_ctrl.sv
module irq_aggregator_ctrl
  import irq_aggregator_pkg::*;
(
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] srcRead,
  output flagCtl_t           flagCtl
);
  // Set has priority over clear in the datapath; an enabled event always sets.
  always_comb begin
    flagCtl.setMask = srcEnable & srcEvent;
    flagCtl.clrMask = ~srcEnable | srcRead;
  end
endmodule

// File: rtl/irq_aggregator_dp.sv
module irq_aggregator_dp
  import irq_aggregator_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  flagCtl_t           flagCtl,
  output logic [NUM_SRC-1:0] flagQ,
  output logic               irqQ
);
  logic [NUM_SRC-1:0] flagNext;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      always_comb begin
        flagNext[i] = flagCtl.setMask[i] | (flagQ[i] & ~flagCtl.clrMask[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      irqQ  <= 1'b0;
    end else begin
      flagQ <= flagNext;
      irqQ  <= |flagQ;
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_aggregator_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] srcRead,
  output logic [NUM_SRC-1:0] statusFlags,
  output logic               timeoutFlag,
  output logic               irqOut
);
  flagCtl_t flagCtl;

  irq_aggregator_ctrl u_ctrl (
    .srcEvent (srcEvent),
    .srcEnable(srcEnable),
    .srcRead  (srcRead),
    .flagCtl  (flagCtl)
  );

  irq_aggregator_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .flagCtl(flagCtl),
    .flagQ  (statusFlags),
    .irqQ   (irqOut)
  );

  assign timeoutFlag = statusFlags[SRC_TMO];
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_aggregator_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcEvent,
  input logic [NUM_SRC-1:0] srcEnable,
  input logic [NUM_SRC-1:0] srcRead,
  input logic [NUM_SRC-1:0] statusFlags,
  input logic               timeoutFlag,
  input logic               irqOut
);
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      // R2 and R4: an enabled event sets the flag, even when a read strobe comes with it
      p_set_r2: assert property (@(posedge clk) disable iff (!rstN)
        (srcEnable[i] && srcEvent[i]) |=> statusFlags[i]);
      // R2: a pending flag holds while its source stays enabled and unread
      p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
        (srcEnable[i] && !srcRead[i] && statusFlags[i]) |=> statusFlags[i]);
      // R3: a read with no event clears the flag
      p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
        (srcEnable[i] && srcRead[i] && !srcEvent[i]) |=> !statusFlags[i]);
      // R5 and R6: a disabled source holds no flag after the edge
      p_disabled_r5: assert property (@(posedge clk) disable iff (!rstN)
        !srcEnable[i] |=> !statusFlags[i]);
    end
  endgenerate

  // R7: the interrupt is the registered OR of the previous flags
  p_irq_or_r7: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (irqOut == $past(|statusFlags)));

  // R8: the timeout status bit tracks its pending flag
  p_tmo_bit_r8: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag == statusFlags[SRC_TMO]);
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .srcEvent   (srcEvent),
  .srcEnable  (srcEnable),
  .srcRead    (srcRead),
  .statusFlags(statusFlags),
  .timeoutFlag(timeoutFlag),
  .irqOut     (irqOut)
);

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] srcEvent = '0;
  logic [N-1:0] srcEnable = '0;
  logic [N-1:0] srcRead = '0;
  logic [N-1:0] statusFlags;
  logic         timeoutFlag;
  logic         irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [N-1:0] mFlags = '0;
  logic         mIrq = 1'b0;

  always #5 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .srcEnable(srcEnable),
    .srcRead(srcRead), .statusFlags(statusFlags), .timeoutFlag(timeoutFlag),
    .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Compare with the model at a falling edge, then drive the next inputs and advance the model.
  task automatic step(input string tag, input logic [N-1:0] en, input logic [N-1:0] ev,
                      input logic [N-1:0] rd);
    @(negedge clk);
    check({tag, " flags"}, statusFlags, mFlags);
    check("R7 irq", {2'b00, irqOut}, {2'b00, mIrq});
    check("R8 timeout bit", {2'b00, timeoutFlag}, {2'b00, mFlags[1]});
    srcEnable = en; srcEvent = ev; srcRead = rd;
    mIrq = |mFlags;
    mFlags = (en & ev) | (mFlags & en & ~rd);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset flags", statusFlags, '0);
    check("R1 reset irq", {2'b00, irqOut}, '0);
    rstN = 1'b1;
    mFlags = '0; mIrq = 1'b0;
    step("R1 after reset", 3'b111, 3'b000, 3'b000);

    // R2: set and hold, one source at a time
    step("R2 set key", 3'b111, 3'b001, 3'b000);
    step("R2 hold", 3'b111, 3'b000, 3'b000);
    step("R2 hold again", 3'b111, 3'b000, 3'b000);
    // R9: reading idle sources leaves the key flag alone
    step("R9 idle read", 3'b111, 3'b000, 3'b110);
    // R7: add two more sources, then read them one by one; irq stays up until the last read
    step("R7 multi set", 3'b111, 3'b110, 3'b000);
    step("R3 read key", 3'b111, 3'b000, 3'b001);
    step("R3 read gpi", 3'b111, 3'b000, 3'b100);
    step("R7 one left", 3'b111, 3'b000, 3'b000);
    step("R3 read tmo", 3'b111, 3'b000, 3'b010);
    step("R7 all read", 3'b111, 3'b000, 3'b000);
    step("R7 drop", 3'b111, 3'b000, 3'b000);
    // R4: event together with its read
    step("R4 same cycle", 3'b111, 3'b100, 3'b100);
    step("R4 stays set", 3'b111, 3'b000, 3'b000);
    // R6: disabling a pending source clears it
    step("R6 disable", 3'b011, 3'b000, 3'b000);
    // R5: events on disabled sources are dropped
    step("R5 disabled ev", 3'b000, 3'b111, 3'b000);
    step("R5 nothing set", 3'b111, 3'b000, 3'b000);
    step("R5 idle", 3'b111, 3'b000, 3'b000);

    // Exhaustive sweep over enable/event/read combinations from evolving flag states
    for (int pass = 0; pass < 4; pass++) begin
      for (int i = 0; i < 512; i++) begin
        int k;
        k = (i * (2 * pass + 37) + pass * 101) % 512;
        step("R2 R3 R4 R5 R6 R9 sweep", k[2:0], k[5:3], k[8:6]);
      end
    end
    step("R7 sweep tail", 3'b111, 3'b000, 3'b111);
    step("R7 sweep end", 3'b111, 3'b000, 3'b000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule